// File: doc/BRIEF.md
# Dual-Issue Instruction Prefetch Queue

This block sits between instruction memory and the two instruction registers of an in-order, two-wide issue front end. It asks memory for 64-bit double-words over a valid/ready request channel and splits each returning double-word into 32-bit instructions. It stores each instruction in a 20-entry circular queue together with its address and the prediction bits that came back with it. Each cycle that decode accepts, it loads zero, one or two of the oldest instructions into the register of pipeline A and the register of pipeline B.

A serialization request flushes the front end. The queue, both instruction registers and every memory response still in flight are dropped in the cycle of the request. Fetching then restarts at the supplied word address. If that address sits in the upper word of a double-word, the first response yields a single instruction. Every later response yields a pair.

Memory is assumed to answer in order. Each request carries an epoch tag, and a response whose tag does not match the current epoch is thrown away. A request goes out only when the queue can take two more words for every request already outstanding plus the new one, so a response is never refused.

Top module: `fpq_top`

## Requirements
- R1: During and right after reset the queue count is 0, the empty flag is 1, both instruction registers are invalid, and the first request asks for address RESET_PC.
- R2: A current-epoch response to a request at a double-word aligned address enqueues two instructions. The first is taken from data bits [31:0] with prediction bits [PW-1:0] at the request address. The second is taken from data bits [63:32] with prediction bits [2*PW-1:PW] at that address plus 4.
- R3: A response to a request whose address has bit 2 set enqueues only the upper word (data [63:32], prediction [2*PW-1:PW]) at that address. The next request goes to the following double-word boundary.
- R4: After an accepted request, the next request address is the next double-word boundary. While a request is not accepted and no flush occurs, it stays valid with a stable address.
- R5: The queue holds at most 20 instructions. A request is issued only when count + 2 × outstanding + 2 ≤ 20, with at most MAX_OUT requests outstanding. With decode stalled, the queue fills to exactly 20 and requests stop.
- R6: When decode accepts, the oldest queued instruction goes to register A and the next one to register B. B is loaded valid only when A is, so a single queued instruction goes to A alone.
- R7: While decode does not accept and no flush occurs, both instruction registers hold their contents.
- R8: A flush takes effect at the same clock edge. In the following cycle the count is 0, both registers are invalid and the request address equals the flush address.
- R9: A response carrying a tag from before the latest flush adds nothing to the queue.
- R10: The count output equals the number of queued instructions, and the empty flag is 1 exactly when that count is 0.
- R11: Instructions reach the registers in program order, including across the wrap of the circular storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Serialization flush request |
| flush_addr_i | input | AW | Word address where fetching resumes |
| mem_req_valid_o | output | 1 | Fetch request valid |
| mem_req_addr_o | output | AW | Word address of the requested instruction |
| mem_req_tag_o | output | TW | Epoch tag of the request |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_rsp_valid_i | input | 1 | Double-word response valid |
| mem_rsp_tag_i | input | TW | Epoch tag echoed by memory |
| mem_rsp_data_i | input | 2*IW | Double-word, lower-address word in the low half |
| mem_rsp_pred_i | input | 2*PW | Prediction bits, lower word in the low half |
| dec_ready_i | input | 1 | Decode takes the instruction registers this cycle |
| ir_a_valid_o | output | 1 | Pipeline A register holds an instruction |
| ir_a_op_o | output | IW | Pipeline A opcode |
| ir_a_addr_o | output | AW | Pipeline A instruction address |
| ir_a_pred_o | output | PW | Pipeline A prediction bits |
| ir_b_valid_o | output | 1 | Pipeline B register holds an instruction |
| ir_b_op_o | output | IW | Pipeline B opcode |
| ir_b_addr_o | output | AW | Pipeline B instruction address |
| ir_b_pred_o | output | PW | Pipeline B prediction bits |
| q_count_o | output | CW | Number of queued instructions |
| q_empty_o | output | 1 | Queue holds no instruction |

## Verification
The bench restarts at an upper-word address and releases responses one at a time. A design that enqueued both halves would show a count of 2 instead of 1 and would hand the unwanted lower word to pipeline A. It flushes while requests are in flight and then releases their responses. A design without epoch checking would refill the queue with instructions from the abandoned path, which the count check and the scoreboard both catch. It stalls decode until the queue saturates, which exposes a reservation rule that overruns 20 entries or stops short of them. Long random runs with flushes to random word addresses drive the pointers around the wrap at every alignment, where a mis-wrapped pointer or a swapped word would break the scoreboard's program order.

// File: rtl/fpq_pkg.sv
`timescale 1ns/1ps
package fpq_pkg;
  typedef int unsigned idx_t;

  // circular index advance for a storage of 'depth' entries
  function automatic idx_t ptr_add(input idx_t p, input idx_t n, input idx_t depth);
    idx_t s;
    s = p + n;
    return (s >= depth) ? s - depth : s;
  endfunction

  // space reservation: every outstanding request may bring two words
  function automatic bit room_ok(input idx_t cnt, input idx_t outst, input idx_t depth);
    return (cnt + 2 * outst + 2) <= depth;
  endfunction

  // words delivered by a double-word whose start word is odd or even
  function automatic logic [1:0] words_in_dw(input logic odd_word);
    return odd_word ? 2'd1 : 2'd2;
  endfunction

  // how many entries decode pulls in one cycle
  function automatic logic [1:0] take_n(input idx_t cnt, input logic ready);
    if (!ready) return 2'd0;
    if (cnt >= 2) return 2'd2;
    return (cnt == 1) ? 2'd1 : 2'd0;
  endfunction
endpackage

// File: rtl/fpq_fetch_ctrl.sv
`timescale 1ns/1ps
module fpq_fetch_ctrl import fpq_pkg::*; #(
  parameter int unsigned AW       = 32,
  parameter int unsigned TW       = 2,
  parameter int unsigned DEPTH    = 20,
  parameter int unsigned MAX_OUT  = 2,
  parameter logic [AW-1:0] RESET_PC = '0,
  parameter int unsigned CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic [AW-1:0] flush_addr_i,
  input  logic [CW-1:0] q_count_i,
  output logic          mem_req_valid_o,
  output logic [AW-1:0] mem_req_addr_o,
  output logic [TW-1:0] mem_req_tag_o,
  input  logic          mem_req_ready_i,
  input  logic          mem_rsp_valid_i,
  input  logic [TW-1:0] mem_rsp_tag_i,
  output logic          rsp_hit_o,
  output logic [AW-1:0] rsp_addr_o
);
  localparam int unsigned OW = $clog2(MAX_OUT + 1);

  logic [AW-1:0] fetch_pc, rsp_pc;
  logic [TW-1:0] epoch;
  logic [OW-1:0] outstanding;
  logic          has_room, req_fire;

  function automatic logic [AW-1:0] next_dw(input logic [AW-1:0] a);
    return {a[AW-1:3] + (AW-3)'(1), 3'b000};
  endfunction

  always_comb begin
    has_room = room_ok(idx_t'(q_count_i), idx_t'(outstanding), DEPTH)
               && (idx_t'(outstanding) < MAX_OUT);
    mem_req_valid_o = has_room && !flush_i;
    req_fire  = mem_req_valid_o && mem_req_ready_i;
    rsp_hit_o = mem_rsp_valid_i && (mem_rsp_tag_i == epoch) && !flush_i;
  end

  assign mem_req_addr_o = fetch_pc;
  assign mem_req_tag_o  = epoch;
  assign rsp_addr_o     = rsp_pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_pc    <= RESET_PC;
      rsp_pc      <= RESET_PC;
      epoch       <= '0;
      outstanding <= '0;
    end else if (flush_i) begin
      fetch_pc    <= flush_addr_i;
      rsp_pc      <= flush_addr_i;
      epoch       <= epoch + TW'(1);
      outstanding <= '0;
    end else begin
      if (req_fire)  fetch_pc <= next_dw(fetch_pc);
      if (rsp_hit_o) rsp_pc   <= next_dw(rsp_pc);
      case ({req_fire, rsp_hit_o})
        2'b10:   outstanding <= outstanding + OW'(1);
        2'b01:   outstanding <= outstanding - OW'(1);
        default: outstanding <= outstanding;
      endcase
    end
  end

  // R5: request only with room reserved for all outstanding words
  a_r5_req_room: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o |-> (idx_t'(q_count_i) + 2 * idx_t'(outstanding) + 2 <= DEPTH));
  a_r5_out_limit: assert property (@(posedge clk) disable iff (!rst_n)
    idx_t'(outstanding) <= MAX_OUT);
  // R4: an unaccepted request holds
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i && !flush_i) |=>
      ((mem_req_valid_o && $stable(mem_req_addr_o)) || flush_i));
  // R8: restart address after flush
  a_r8_restart_addr: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (mem_req_addr_o == $past(flush_addr_i)));
endmodule

// File: rtl/fpq_store.sv
`timescale 1ns/1ps
module fpq_store import fpq_pkg::*; #(
  parameter int unsigned AW    = 32,
  parameter int unsigned IW    = 32,
  parameter int unsigned PW    = 2,
  parameter int unsigned DEPTH = 20,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic [1:0]    enq_n_i,
  input  logic [IW-1:0] enq0_op_i,
  input  logic [AW-1:0] enq0_addr_i,
  input  logic [PW-1:0] enq0_pred_i,
  input  logic [IW-1:0] enq1_op_i,
  input  logic [AW-1:0] enq1_addr_i,
  input  logic [PW-1:0] enq1_pred_i,
  input  logic [1:0]    deq_n_i,
  output logic [IW-1:0] hd0_op_o,
  output logic [AW-1:0] hd0_addr_o,
  output logic [PW-1:0] hd0_pred_o,
  output logic [IW-1:0] hd1_op_o,
  output logic [AW-1:0] hd1_addr_o,
  output logic [PW-1:0] hd1_pred_o,
  output logic [CW-1:0] count_o
);
  localparam int unsigned PTRW = $clog2(DEPTH);

  logic [IW-1:0] op_mem   [DEPTH];
  logic [AW-1:0] addr_mem [DEPTH];
  logic [PW-1:0] pred_mem [DEPTH];

  logic [PTRW-1:0] head, tail, head1, tail1;
  logic [CW-1:0]   count_q;

  always_comb begin
    head1 = PTRW'(ptr_add(idx_t'(head), 1, DEPTH));
    tail1 = PTRW'(ptr_add(idx_t'(tail), 1, DEPTH));
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam logic [PTRW-1:0] IDX = PTRW'(g);
    logic we0, we1;
    always_comb begin
      we0 = (enq_n_i != 2'd0) && (tail == IDX);
      we1 = (enq_n_i == 2'd2) && (tail1 == IDX);
    end
    // a flush wipes opcode, address and prediction metadata alike
    always_ff @(posedge clk) begin
      if (!rst_n || flush_i) begin
        op_mem[g]   <= '0;
        addr_mem[g] <= '0;
        pred_mem[g] <= '0;
      end else if (we0) begin
        op_mem[g]   <= enq0_op_i;
        addr_mem[g] <= enq0_addr_i;
        pred_mem[g] <= enq0_pred_i;
      end else if (we1) begin
        op_mem[g]   <= enq1_op_i;
        addr_mem[g] <= enq1_addr_i;
        pred_mem[g] <= enq1_pred_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush_i) begin
      head    <= '0;
      tail    <= '0;
      count_q <= '0;
    end else begin
      head    <= PTRW'(ptr_add(idx_t'(head), idx_t'(deq_n_i), DEPTH));
      tail    <= PTRW'(ptr_add(idx_t'(tail), idx_t'(enq_n_i), DEPTH));
      count_q <= count_q + CW'(enq_n_i) - CW'(deq_n_i);
    end
  end

  assign hd0_op_o   = op_mem[head];
  assign hd0_addr_o = addr_mem[head];
  assign hd0_pred_o = pred_mem[head];
  assign hd1_op_o   = op_mem[head1];
  assign hd1_addr_o = addr_mem[head1];
  assign hd1_pred_o = pred_mem[head1];
  assign count_o    = count_q;

  // R5: never more entries than slots
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    idx_t'(count_q) <= DEPTH);
  // R6: never pull more than is stored
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    idx_t'(deq_n_i) <= idx_t'(count_q));
  // R8: flush empties the queue at the next edge
  a_r8_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (count_q == '0));
endmodule

// File: rtl/fpq_issue.sv
`timescale 1ns/1ps
module fpq_issue import fpq_pkg::*; #(
  parameter int unsigned AW = 32,
  parameter int unsigned IW = 32,
  parameter int unsigned PW = 2,
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          dec_ready_i,
  input  logic [CW-1:0] q_count_i,
  input  logic [IW-1:0] hd0_op_i,
  input  logic [AW-1:0] hd0_addr_i,
  input  logic [PW-1:0] hd0_pred_i,
  input  logic [IW-1:0] hd1_op_i,
  input  logic [AW-1:0] hd1_addr_i,
  input  logic [PW-1:0] hd1_pred_i,
  output logic [1:0]    deq_n_o,
  output logic          a_valid_o,
  output logic [IW-1:0] a_op_o,
  output logic [AW-1:0] a_addr_o,
  output logic [PW-1:0] a_pred_o,
  output logic          b_valid_o,
  output logic [IW-1:0] b_op_o,
  output logic [AW-1:0] b_addr_o,
  output logic [PW-1:0] b_pred_o
);
  always_comb deq_n_o = flush_i ? 2'd0 : take_n(idx_t'(q_count_i), dec_ready_i);

  always_ff @(posedge clk) begin
    if (!rst_n || flush_i) begin
      a_valid_o <= 1'b0;
      b_valid_o <= 1'b0;
      a_op_o <= '0; a_addr_o <= '0; a_pred_o <= '0;
      b_op_o <= '0; b_addr_o <= '0; b_pred_o <= '0;
    end else if (dec_ready_i) begin
      a_valid_o <= (deq_n_o != 2'd0);
      b_valid_o <= (deq_n_o == 2'd2);
      a_op_o <= hd0_op_i; a_addr_o <= hd0_addr_i; a_pred_o <= hd0_pred_i;
      b_op_o <= hd1_op_i; b_addr_o <= hd1_addr_i; b_pred_o <= hd1_pred_i;
    end
  end

  // R6: pipeline B only ever runs alongside pipeline A
  a_r6_b_needs_a: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid_o |-> a_valid_o);
  // R7: stalled decode leaves both registers untouched
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_ready_i && !flush_i) |=>
      ($stable(a_valid_o) && $stable(a_addr_o) && $stable(b_valid_o) && $stable(b_addr_o)));
endmodule

// File: rtl/fpq_top.sv
`timescale 1ns/1ps
module fpq_top import fpq_pkg::*; #(
  parameter int unsigned AW       = 32,
  parameter int unsigned IW       = 32,
  parameter int unsigned PW       = 2,
  parameter int unsigned TW       = 2,
  parameter int unsigned DEPTH    = 20,
  parameter int unsigned MAX_OUT  = 2,
  parameter logic [AW-1:0] RESET_PC = 32'h0000_1000,
  parameter int unsigned CW       = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush_i,
  input  logic [AW-1:0]   flush_addr_i,
  output logic            mem_req_valid_o,
  output logic [AW-1:0]   mem_req_addr_o,
  output logic [TW-1:0]   mem_req_tag_o,
  input  logic            mem_req_ready_i,
  input  logic            mem_rsp_valid_i,
  input  logic [TW-1:0]   mem_rsp_tag_i,
  input  logic [2*IW-1:0] mem_rsp_data_i,
  input  logic [2*PW-1:0] mem_rsp_pred_i,
  input  logic            dec_ready_i,
  output logic            ir_a_valid_o,
  output logic [IW-1:0]   ir_a_op_o,
  output logic [AW-1:0]   ir_a_addr_o,
  output logic [PW-1:0]   ir_a_pred_o,
  output logic            ir_b_valid_o,
  output logic [IW-1:0]   ir_b_op_o,
  output logic [AW-1:0]   ir_b_addr_o,
  output logic [PW-1:0]   ir_b_pred_o,
  output logic [CW-1:0]   q_count_o,
  output logic            q_empty_o
);
  // named internal events
  logic          rsp_hit;
  logic [AW-1:0] rsp_addr;
  logic          rsp_odd;
  logic [1:0]    enq_n, deq_n;
  logic [IW-1:0] enq0_op;
  logic [PW-1:0] enq0_pred;
  logic [IW-1:0] hd0_op, hd1_op;
  logic [AW-1:0] hd0_addr, hd1_addr;
  logic [PW-1:0] hd0_pred, hd1_pred;

  fpq_fetch_ctrl #(.AW(AW), .TW(TW), .DEPTH(DEPTH), .MAX_OUT(MAX_OUT),
                   .RESET_PC(RESET_PC), .CW(CW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_addr_i(flush_addr_i),
    .q_count_i(q_count_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_addr_o(mem_req_addr_o),
    .mem_req_tag_o(mem_req_tag_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_tag_i(mem_rsp_tag_i),
    .rsp_hit_o(rsp_hit), .rsp_addr_o(rsp_addr)
  );

  // odd start word: only the upper half of the double-word is wanted
  always_comb begin
    rsp_odd   = rsp_addr[2];
    enq_n     = rsp_hit ? words_in_dw(rsp_odd) : 2'd0;
    enq0_op   = rsp_odd ? mem_rsp_data_i[2*IW-1:IW] : mem_rsp_data_i[IW-1:0];
    enq0_pred = rsp_odd ? mem_rsp_pred_i[2*PW-1:PW] : mem_rsp_pred_i[PW-1:0];
  end

  fpq_store #(.AW(AW), .IW(IW), .PW(PW), .DEPTH(DEPTH), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .enq_n_i(enq_n),
    .enq0_op_i(enq0_op), .enq0_addr_i(rsp_addr), .enq0_pred_i(enq0_pred),
    .enq1_op_i(mem_rsp_data_i[2*IW-1:IW]), .enq1_addr_i(rsp_addr + AW'(4)),
    .enq1_pred_i(mem_rsp_pred_i[2*PW-1:PW]),
    .deq_n_i(deq_n),
    .hd0_op_o(hd0_op), .hd0_addr_o(hd0_addr), .hd0_pred_o(hd0_pred),
    .hd1_op_o(hd1_op), .hd1_addr_o(hd1_addr), .hd1_pred_o(hd1_pred),
    .count_o(q_count_o)
  );

  fpq_issue #(.AW(AW), .IW(IW), .PW(PW), .CW(CW)) u_issue (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .dec_ready_i(dec_ready_i),
    .q_count_i(q_count_o),
    .hd0_op_i(hd0_op), .hd0_addr_i(hd0_addr), .hd0_pred_i(hd0_pred),
    .hd1_op_i(hd1_op), .hd1_addr_i(hd1_addr), .hd1_pred_i(hd1_pred),
    .deq_n_o(deq_n),
    .a_valid_o(ir_a_valid_o), .a_op_o(ir_a_op_o), .a_addr_o(ir_a_addr_o), .a_pred_o(ir_a_pred_o),
    .b_valid_o(ir_b_valid_o), .b_op_o(ir_b_op_o), .b_addr_o(ir_b_addr_o), .b_pred_o(ir_b_pred_o)
  );

  assign q_empty_o = (q_count_o == '0);

  // R9: a response from an older epoch never grows the queue
  a_r9_stale_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid_i && (mem_rsp_tag_i != mem_req_tag_o) && !flush_i) |=>
      (q_count_o <= $past(q_count_o)));
  // R3: an odd-word response adds exactly one entry
  a_r3_single_word: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && rsp_odd && deq_n == 2'd0) |=> (q_count_o == $past(q_count_o) + CW'(1)));
endmodule

// File: tb/fpq_top_bench.sv
`timescale 1ns/1ps
module fpq_top_bench;
  localparam logic [31:0] RST_PC = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_i = 1'b0;
  logic [31:0] flush_addr_i = '0;
  logic        mem_req_valid_o;
  logic [31:0] mem_req_addr_o;
  logic [1:0]  mem_req_tag_o;
  logic        mem_req_ready_i = 1'b0;
  logic        mem_rsp_valid_i = 1'b0;
  logic [1:0]  mem_rsp_tag_i = '0;
  logic [63:0] mem_rsp_data_i = '0;
  logic [3:0]  mem_rsp_pred_i = '0;
  logic        dec_ready_i = 1'b0;
  logic        ir_a_valid_o, ir_b_valid_o;
  logic [31:0] ir_a_op_o, ir_a_addr_o, ir_b_op_o, ir_b_addr_o;
  logic [1:0]  ir_a_pred_o, ir_b_pred_o;
  logic [4:0]  q_count_o;
  logic        q_empty_o;

  fpq_top #(.RESET_PC(RST_PC)) u_fpq_top (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_addr_i(flush_addr_i),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_addr_o(mem_req_addr_o),
    .mem_req_tag_o(mem_req_tag_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_tag_i(mem_rsp_tag_i),
    .mem_rsp_data_i(mem_rsp_data_i), .mem_rsp_pred_i(mem_rsp_pred_i),
    .dec_ready_i(dec_ready_i),
    .ir_a_valid_o(ir_a_valid_o), .ir_a_op_o(ir_a_op_o), .ir_a_addr_o(ir_a_addr_o), .ir_a_pred_o(ir_a_pred_o),
    .ir_b_valid_o(ir_b_valid_o), .ir_b_op_o(ir_b_op_o), .ir_b_addr_o(ir_b_addr_o), .ir_b_pred_o(ir_b_pred_o),
    .q_count_o(q_count_o), .q_empty_o(q_empty_o)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct { logic [31:0] addr; logic [1:0] tag; int ep; } pend_t;
  pend_t       pending[$];
  logic [31:0] exp_q[$];
  logic [31:0] exp_req_pc = RST_PC;
  int          bench_ep = 0;

  int dec_pct = 0, ready_pct = 0, rsp_pct = 0, rsp_budget = -1;
  bit do_flush = 0;
  logic [31:0] flush_target = '0;

  bit          have_prev = 0, prev_dec = 0, prev_flush = 0, prev_a_v = 0, prev_b_v = 0;
  logic [31:0] prev_a_addr = '0, prev_b_addr = '0;

  function automatic logic [31:0] op_of(logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
  endfunction
  function automatic logic [1:0] pred_of(logic [31:0] a);
    return a[3:2] ^ 2'b01;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
      finish_run();
    end
  end

  // monitor side of the scoreboard: one issue register against the queue head
  task automatic score(logic [31:0] addr, logic [31:0] op, logic [1:0] pred, string slot);
    logic [31:0] e;
    if (exp_q.size() == 0) begin
      chk(0, "R11", {slot, " unexpected instruction"}, addr, 0);
      return;
    end
    e = exp_q.pop_front();
    chk(addr == e, "R11", {slot, " address order"}, addr, e);
    chk(op == op_of(e), "R2", {slot, " opcode word"}, op, op_of(e));
    chk(pred == pred_of(e), "R2", {slot, " prediction bits"}, pred, pred_of(e));
  endtask

  // one cycle: drive at the falling edge, sample just after
  task automatic step();
    bit fl;
    @(negedge clk);
    fl = do_flush;
    flush_i = fl;
    flush_addr_i = flush_target;
    if (fl) begin
      bench_ep++;
      exp_q.delete();
      exp_req_pc = flush_target;
    end
    dec_ready_i = ($urandom_range(99) < dec_pct);
    mem_req_ready_i = !fl && ($urandom_range(99) < ready_pct);
    mem_rsp_valid_i = 1'b0;
    if (pending.size() > 0 && rsp_budget != 0 && $urandom_range(99) < rsp_pct) begin
      pend_t p;
      logic [31:0] base;
      p = pending.pop_front();
      base = {p.addr[31:3], 3'b000};
      mem_rsp_valid_i = 1'b1;
      mem_rsp_tag_i   = p.tag;
      mem_rsp_data_i  = {op_of(base + 4), op_of(base)};
      mem_rsp_pred_i  = {pred_of(base + 4), pred_of(base)};
      if (rsp_budget > 0) rsp_budget--;
      // driver side of the scoreboard: current-path words become expected items
      if (p.ep == bench_ep) begin
        if (p.addr[2]) exp_q.push_back(p.addr);
        else begin
          exp_q.push_back(base);
          exp_q.push_back(base + 4);
        end
      end
    end
    #1;
    if (ir_b_valid_o && !ir_a_valid_o) chk(0, "R6", "B valid without A", 1, 0);
    if (!fl && dec_ready_i) begin
      if (ir_a_valid_o) score(ir_a_addr_o, ir_a_op_o, ir_a_pred_o, "A");
      if (ir_b_valid_o) score(ir_b_addr_o, ir_b_op_o, ir_b_pred_o, "B");
    end
    if (have_prev && !prev_dec && !prev_flush) begin
      chk(ir_a_valid_o == prev_a_v && ir_a_addr_o == prev_a_addr, "R7", "A held", ir_a_addr_o, prev_a_addr);
      chk(ir_b_valid_o == prev_b_v && ir_b_addr_o == prev_b_addr, "R7", "B held", ir_b_addr_o, prev_b_addr);
    end
    if (have_prev && prev_flush) begin
      chk(q_count_o == 0, "R8", "count after flush", q_count_o, 0);
      chk(!ir_a_valid_o && !ir_b_valid_o, "R8", "registers after flush", {ir_a_valid_o, ir_b_valid_o}, 0);
    end
    if (mem_req_valid_o && mem_req_ready_i) begin
      pend_t n;
      chk(mem_req_addr_o == exp_req_pc, "R4", "request address", mem_req_addr_o, exp_req_pc);
      n.addr = mem_req_addr_o; n.tag = mem_req_tag_o; n.ep = bench_ep;
      pending.push_back(n);
      exp_req_pc = {mem_req_addr_o[31:3], 3'b000} + 32'd8;
    end
    chk(q_count_o <= 20, "R5", "count bound", q_count_o, 20);
    chk(q_empty_o == (q_count_o == 0), "R10", "empty flag", q_empty_o, q_count_o == 0);
    have_prev = 1; prev_dec = dec_ready_i; prev_flush = fl;
    prev_a_v = ir_a_valid_o; prev_a_addr = ir_a_addr_o;
    prev_b_v = ir_b_valid_o; prev_b_addr = ir_b_addr_o;
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic flush_to(logic [31:0] a);
    flush_target = a;
    do_flush = 1;
    step();
    do_flush = 0;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    chk(q_count_o == 0 && q_empty_o, "R1", "count/empty in reset", {q_count_o, q_empty_o}, 1);
    chk(!ir_a_valid_o && !ir_b_valid_o, "R1", "registers in reset", {ir_a_valid_o, ir_b_valid_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    chk(mem_req_valid_o && mem_req_addr_o == RST_PC, "R1", "first request", mem_req_addr_o, RST_PC);

    // R5: stalled decode saturates the queue at exactly 20
    ready_pct = 100; rsp_pct = 100; dec_pct = 0;
    steps(60);
    chk(q_count_o == 20, "R5", "full count", q_count_o, 20);
    chk(!mem_req_valid_o, "R5", "no request when full", mem_req_valid_o, 0);
    chk(!ir_a_valid_o, "R7", "no load while stalled", ir_a_valid_o, 0);

    // R6 R11: drain through both pipelines while streaming
    dec_pct = 100;
    steps(50);

    // R3: restart at an upper word
    ready_pct = 0; steps(10);
    rsp_pct = 0; flush_to(32'h0000_2004);
    ready_pct = 100; dec_pct = 0;
    steps(5);
    chk(q_count_o == 0, "R3", "nothing before response", q_count_o, 0);
    rsp_budget = 1; rsp_pct = 100;
    steps(3);
    chk(q_count_o == 1, "R3", "single word from odd start", q_count_o, 1);
    rsp_budget = 1;
    steps(3);
    chk(q_count_o == 3, "R2", "pair after odd start", q_count_o, 3);
    dec_pct = 100;
    steps(3);
    chk(q_count_o == 0, "R6", "three drained", q_count_o, 0);

    // R9: responses in flight at a flush are dropped
    ready_pct = 0;
    flush_to(32'h0000_3000);
    rsp_budget = -1;
    steps(6);
    chk(pending.size() == 0, "R9", "stale responses delivered", pending.size(), 0);
    chk(q_count_o == 0, "R9", "stale responses dropped", q_count_o, 0);
    chk(!ir_a_valid_o, "R9", "no stale issue", ir_a_valid_o, 0);

    // R11: random traffic with occasional flushes to random word addresses
    ready_pct = 70; rsp_pct = 55; dec_pct = 60;
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(149) == 0) flush_to({16'h0004, 4'h0, 10'($urandom), 2'b00});
      else step();
    end

    // R10: final drain
    ready_pct = 0; rsp_pct = 100; dec_pct = 100;
    steps(40);
    chk(q_count_o == 0 && q_empty_o, "R10", "drained empty", {q_count_o, q_empty_o}, 1);
    chk(exp_q.size() == 0, "R11", "all expected issued", exp_q.size(), 0);
    finish_run();
  end
endmodule